// File: doc/BRIEF.md
# Display Controller Command Decoder

This block is the front end of a display controller. A host offers bytes together with a flag that says whether each byte is a command or a parameter. The byte and its flag go into a small nine-bit-wide FIFO. The decoder drains the FIFO one entry per cycle, unless the drawing engine reports that it is busy. A command entry becomes the current command and selects a starting slot and an expected byte count from a constant lookup. The parameter entries that follow fill consecutive slots of a 40-byte parameter store. Neighbouring logic reads that store through an index port.

Several commands also act directly. Some turn display output on or off. The vector-execute and text-execute commands each issue a one-cycle start pulse and restore the vector parameter slots to their default values. A write-type command raises a one-cycle write pulse on its own once its last parameter has been stored. A combinational status byte reports the FIFO state, engine activity, the vertical sync input, and whether the current position in the raster line falls within the horizontal sync window.

Top module: `dispctl_cmd_decoder`

## Requirements
- R1: FIFO entries are nine bits wide. Bit 8 set marks a command and bit 8 clear marks a parameter. Entries are decoded in arrival order, one per cycle. Nothing is decoded while `engine_busy` is high.
- R2: A byte offered while the FIFO holds DEPTH entries is dropped. Status bit 1 reads 1 when the FIFO is full and status bit 2 reads 1 when it is empty.
- R3: A command replaces the current command and restarts parameter collection from its own lookup entry. Any parameters still expected by the previous command are abandoned.
- R4: A command whose bits 6:5 equal 01 is also stored in slot 36.
- R5: `disp_en` is 0 after reset. It is set by 0x6B and 0x0F and cleared by 0x0C and 0x0E. Every other command leaves it unchanged.
- R6: The lookup gives each command a start slot and a count, as slot/count: 0x0E and 0x0F give 0/8; 0x4B gives 8/3; 0x47 gives 11/1; 0x49 gives 12/3; 0x4C gives 15/11; 0x78 gives 26/8; 0x4A gives 34/2; any byte with bits 6:5 = 01 gives 37/2. Every other byte has a count of 0. Each accepted parameter is written at the current slot, after which the slot advances by one.
- R7: `write_go` pulses for exactly one cycle when the count reaches zero, provided the current command ANDed with 0xE4 equals 0x20. It does not pulse for any other command.
- R8: Command 0x6C pulses `vect_go` for one cycle and command 0x68 pulses `text_go` for one cycle. Both reload slots 16 to 25 with 00,00,08,00,08,00,FF,FF,FF,FF and leave slot 15 unchanged. The same values are present after reset, and every other slot resets to 0.
- R9: Status bit 7 is always 1, bit 5 equals `vsync_in`, bit 3 equals `engine_busy`, and bits 4 and 0 are 0. Bit 6 is 1 while (clock cycles since reset) mod LINE_LEN is below HSYNC_LEN.
- R10: Parameters that arrive after the count has reached zero are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host offers a byte this cycle |
| wr_is_cmd | input | 1 | Offered byte is a command (tag bit) |
| wr_data | input | 8 | Offered byte |
| engine_busy | input | 1 | Drawing engine busy; decoding stalls |
| vsync_in | input | 1 | Vertical sync flag for status |
| rd_idx | input | 6 | Parameter slot to read |
| rd_data | output | 8 | Content of the selected slot (0 beyond slot 39) |
| status | output | 8 | Status byte |
| disp_en | output | 1 | Display enable |
| write_go | output | 1 | Write-action start pulse |
| vect_go | output | 1 | Vector-engine start pulse |
| text_go | output | 1 | Text-engine start pulse |

## Verification
The main sweep sends each of the 256 opcodes in turn, followed by twelve parameters whose values vary with the opcode. It then compares all forty slots, the pulse counts and the display enable against a model built from the lookup table. This separates correct slot placement from off-by-one pointers, shows whether surplus parameters are discarded, and distinguishes write-type opcodes that must fire from near-misses such as 0x24 and 0xA0. Directed patterns cover a command cut short mid-parameter. They also fill the FIFO while the engine is busy, which separates held entries from dropped ones. A free-running check of the status byte across several raster lines exercises the sync-window bit.

// File: rtl/dispctl_cmd_decoder.sv
`timescale 1ns/1ps
module dispctl_cmd_decoder #(
  parameter int DEPTH     = 4,
  parameter int LINE_LEN  = 16,
  parameter int HSYNC_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_is_cmd,
  input  logic [7:0] wr_data,
  input  logic       engine_busy,
  input  logic       vsync_in,
  input  logic [5:0] rd_idx,
  output logic [7:0] rd_data,
  output logic [7:0] status,
  output logic       disp_en,
  output logic       write_go,
  output logic       vect_go,
  output logic       text_go
);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW    = $clog2(LINE_LEN + 1);
  localparam int NSLOT = 40;
  localparam int VEC   = 15;
  localparam int WMODE = 36;
  localparam logic [7:0] OP_SYNC_OFF = 8'h0E, OP_SYNC_ON = 8'h0F;
  localparam logic [7:0] OP_START = 8'h6B, OP_STOP = 8'h0C;
  localparam logic [7:0] OP_VEXEC = 8'h6C, OP_TEXEC = 8'h68;

  function automatic logic [7:0] vdef(input int i);
    if (i == VEC + 3 || i == VEC + 5) return 8'h08;
    if (i >= VEC + 7 && i <= VEC + 10) return 8'hFF;
    return 8'h00;
  endfunction

  // host FIFO
  logic [8:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   fcnt;
  logic          full, empty, push, pop;

  assign full  = fcnt == (AW+1)'(DEPTH);
  assign empty = fcnt == '0;
  assign push  = wr_en & ~full;
  assign pop   = ~empty & ~engine_busy;

  always_ff @(posedge clk)
    if (push) mem[wp] <= {wr_is_cmd, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   fcnt <= fcnt + 1'b1;
        2'b01:   fcnt <= fcnt - 1'b1;
        default: fcnt <= fcnt;
      endcase
    end
  end

  logic [8:0] head;
  logic [7:0] hb;
  logic       is_cmd;
  assign head   = mem[rp];
  assign hb     = head[7:0];
  assign is_cmd = head[8];

  // command lookup
  logic [5:0] lut_pos;
  logic [3:0] lut_cnt;
  always_comb begin
    lut_pos = 6'd0;
    lut_cnt = 4'd0;
    if (hb[6:5] == 2'b01) begin
      lut_pos = 6'd37; lut_cnt = 4'd2;
    end else begin
      case (hb)
        OP_SYNC_OFF, OP_SYNC_ON: begin lut_pos = 6'd0;  lut_cnt = 4'd8;  end
        8'h4B:                   begin lut_pos = 6'd8;  lut_cnt = 4'd3;  end
        8'h47:                   begin lut_pos = 6'd11; lut_cnt = 4'd1;  end
        8'h49:                   begin lut_pos = 6'd12; lut_cnt = 4'd3;  end
        8'h4C:                   begin lut_pos = 6'd15; lut_cnt = 4'd11; end
        8'h78:                   begin lut_pos = 6'd26; lut_cnt = 4'd8;  end
        8'h4A:                   begin lut_pos = 6'd34; lut_cnt = 4'd2;  end
        default:                 begin lut_pos = 6'd0;  lut_cnt = 4'd0;  end
      endcase
    end
  end

  // decoder
  logic [7:0] cmd_q;
  logic [5:0] ptr;
  logic [3:0] rem;
  logic [7:0] prm [NSLOT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; ptr <= '0; rem <= '0;
      disp_en <= 1'b0; write_go <= 1'b0; vect_go <= 1'b0; text_go <= 1'b0;
      for (int i = 0; i < NSLOT; i++) prm[i] <= vdef(i);
    end else begin
      write_go <= 1'b0;
      vect_go  <= 1'b0;
      text_go  <= 1'b0;
      if (pop) begin
        if (is_cmd) begin
          cmd_q <= hb;
          ptr   <= lut_pos;
          rem   <= lut_cnt;
          if (hb[6:5] == 2'b01) prm[WMODE] <= hb;
          if (hb == OP_START || hb == OP_SYNC_ON) disp_en <= 1'b1;
          if (hb == OP_STOP || hb == OP_SYNC_OFF) disp_en <= 1'b0;
          if (hb == OP_VEXEC || hb == OP_TEXEC) begin
            vect_go <= hb == OP_VEXEC;
            text_go <= hb == OP_TEXEC;
            for (int i = VEC + 1; i <= VEC + 10; i++) prm[i] <= vdef(i);
          end
        end else if (rem != 4'd0) begin
          prm[ptr] <= hb;
          ptr      <= ptr + 6'd1;
          rem      <= rem - 4'd1;
          if (rem == 4'd1 && (cmd_q & 8'hE4) == 8'h20) write_go <= 1'b1;
        end
      end
    end
  end

  assign rd_data = (rd_idx < 6'(NSLOT)) ? prm[rd_idx] : 8'h00;

  // raster position and status
  logic [LW-1:0] lpos;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lpos <= '0;
    else        lpos <= (lpos == LW'(LINE_LEN - 1)) ? '0 : lpos + 1'b1;

  assign status = {1'b1, lpos < LW'(HSYNC_LEN), vsync_in, 1'b0,
                   engine_busy, empty, full, 1'b0};

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= (AW+1)'(DEPTH)); // R2
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && engine_busy) |=> fcnt == $past(fcnt)); // R2
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (engine_busy && !wr_en) |=> $stable(fcnt)); // R1
  AST_ONE_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({write_go, vect_go, text_go})); // R7
  AST_WGO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    write_go |=> !write_go); // R7
  AST_EN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && is_cmd && hb == OP_START) |=> disp_en); // R5
  AST_VEC_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    vect_go |-> (prm[VEC + 3] == 8'h08 && prm[VEC + 10] == 8'hFF)); // R8
  AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (lpos == LW'(LINE_LEN - 1)) |=> lpos == '0); // R9
endmodule

// File: tb/test_dispctl_cmd_decoder.sv
`timescale 1ns/1ps
module test_dispctl_cmd_decoder;
  localparam int LL = 16, HS = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_is_cmd = 0, engine_busy = 0, vsync_in = 0;
  logic [7:0] wr_data = 0;
  logic [5:0] rd_idx = 0;
  logic [7:0] rd_data, status;
  logic disp_en, write_go, vect_go, text_go;

  always #2.5 clk = ~clk;

  dispctl_cmd_decoder #(.DEPTH(4), .LINE_LEN(LL), .HSYNC_LEN(HS)) i_dispctl_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_is_cmd(wr_is_cmd), .wr_data(wr_data),
    .engine_busy(engine_busy), .vsync_in(vsync_in), .rd_idx(rd_idx), .rd_data(rd_data),
    .status(status), .disp_en(disp_en), .write_go(write_go), .vect_go(vect_go),
    .text_go(text_go));

  int total = 0, bad = 0, wd = 0;
  int nw = 0, nv = 0, nt = 0;
  int ew = 0, ev = 0, et = 0;
  int m[40];
  int mptr = 0, mrem = 0, mcmd = 0, men = 0;
  int cyc = 0;

  always @(negedge clk) begin
    if (write_go) nw++;
    if (vect_go)  nv++;
    if (text_go)  nt++;
  end

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=%0d exp<=150000 cycles", wd);
      finish_up();
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int vdef(int i);
    if (i == 18 || i == 20) return 8'h08;
    if (i >= 22 && i <= 25) return 8'hFF;
    return 0;
  endfunction

  // R6 table
  function automatic void lut(input int c, output int pos, output int cnt);
    pos = 0; cnt = 0;
    if (((c >> 5) & 3) == 1) begin pos = 37; cnt = 2; end
    else case (c)
      8'h0E, 8'h0F: begin pos = 0;  cnt = 8;  end
      8'h4B:        begin pos = 8;  cnt = 3;  end
      8'h47:        begin pos = 11; cnt = 1;  end
      8'h49:        begin pos = 12; cnt = 3;  end
      8'h4C:        begin pos = 15; cnt = 11; end
      8'h78:        begin pos = 26; cnt = 8;  end
      8'h4A:        begin pos = 34; cnt = 2;  end
      default:      begin pos = 0;  cnt = 0;  end
    endcase
  endfunction

  function automatic void m_cmd(int c);
    mcmd = c;
    lut(c, mptr, mrem);
    if (((c >> 5) & 3) == 1) m[36] = c;
    if (c == 8'h6B || c == 8'h0F) men = 1;
    if (c == 8'h0C || c == 8'h0E) men = 0;
    if (c == 8'h6C) ev++;
    if (c == 8'h68) et++;
    if (c == 8'h6C || c == 8'h68)
      for (int i = 16; i <= 25; i++) m[i] = vdef(i);
  endfunction

  function automatic void m_par(int p);
    if (mrem > 0) begin
      m[mptr] = p; mptr++; mrem--;
      if (mrem == 0 && (mcmd & 8'hE4) == 8'h20) ew++;
    end
  endfunction

  task automatic put(bit c, int d);
    @(negedge clk);
    wr_en = 1; wr_is_cmd = c; wr_data = d[7:0];
  endtask

  task automatic stop_wr;
    @(negedge clk);
    wr_en = 0; wr_is_cmd = 0;
  endtask

  task automatic rd(int idx, output int v);
    @(negedge clk);
    rd_idx = idx[5:0];
    #1 v = rd_data;
  endtask

  initial begin
    int v;
    for (int i = 0; i < 40; i++) m[i] = vdef(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk("R9 status after reset", status & 8'hBE, 8'h84);
    chk("R5 disp_en after reset", disp_en, 0);
    rd(18, v); chk("R8 vector default slot 18", v, 8'h08);
    rd(22, v); chk("R8 vector default slot 22", v, 8'hFF);
    rd(0, v);  chk("R8 other slot resets to 0", v, 0);

    // R9 raster window over several lines, plus vsync and busy bits
    for (int k = 0; k < 3 * LL; k++) begin
      @(negedge clk);
      chk("R9 hsync window bit", status[6], ((cyc % LL) < HS) ? 1 : 0);
    end
    vsync_in = 1; engine_busy = 1;
    @(negedge clk);
    chk("R9 vsync and busy bits", status & 8'hBF, 8'hAC);
    vsync_in = 0; engine_busy = 0;

    // R1/R2: hold while busy, fill, drop
    engine_busy = 1;
    put(1, 8'h4C); put(0, 8'hA1); put(0, 8'hB2); put(0, 8'hC3);
    put(0, 8'hD4); put(0, 8'hE5);
    stop_wr();
    chk("R2 full flag", status[1], 1);
    chk("R2 empty flag clear", status[2], 0);
    rd(15, v); chk("R1 nothing decoded while busy", v, 0);
    engine_busy = 0;
    repeat (6) @(negedge clk);
    chk("R2 empty after drain", status[2], 1);
    put(0, 8'hF6); stop_wr(); repeat (3) @(negedge clk);
    m_cmd(8'h4C); m_par(8'hA1); m_par(8'hB2); m_par(8'hC3); m_par(8'hF6);
    rd(15, v); chk("R1 order slot 15", v, 8'hA1);
    rd(17, v); chk("R1 order slot 17", v, 8'hC3);
    rd(18, v); chk("R2 dropped bytes skipped", v, 8'hF6);

    // R3: command cut short
    m_cmd(8'h4A); m_par(8'h5A); m_cmd(8'h47); m_par(8'h66);
    put(1, 8'h4A); put(0, 8'h5A); put(1, 8'h47); put(0, 8'h66);
    stop_wr(); repeat (3) @(negedge clk);
    rd(34, v); chk("R3 partial params kept", v, 8'h5A);
    rd(35, v); chk("R3 abandoned slot untouched", v, 0);
    rd(11, v); chk("R3 new command slot", v, 8'h66);

    // sweep every opcode with 12 parameters
    for (int c = 0; c < 256; c++) begin
      m_cmd(c);
      put(1, c);
      for (int k = 0; k < 12; k++) begin
        int p;
        p = (c * 5 + k * 37 + 3) & 8'hFF;
        m_par(p);
        put(0, p);
      end
      stop_wr();
      repeat (3) @(negedge clk);
      chk("R5 disp_en", disp_en, men);
      chk("R7 write pulses", nw, ew);
      chk("R8 vector pulses", nv, ev);
      chk("R8 text pulses", nt, et);
      for (int i = 0; i < 40; i++) begin
        rd(i, v);
        chk((i == 36) ? "R4 write-mode slot" : "R6 R10 slot contents", v, m[i]);
      end
    end
    rd(45, v); chk("R6 read beyond store", v, 0);
    finish_up();
  end
endmodule